// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns the address field of a memory-referencing operation into a 15-bit operand address. It takes either a two-byte absolute field or a one-byte relative displacement, together with the address of the following instruction and the current value of the index register the operation names. From the field it decodes an indirection flag and, for data operations, an indexing mode. It also owns the 2-bit page register that supplies the top address bits of every data access.

When the field asks for indirection, the block reads a two-byte pointer over a simple request/ready port and then applies any indexing to the pointer. Each operation ends with a one-cycle result strobe carrying the final address and, where the mode requires it, a write-back of the updated index value. Moving the data itself, fetching instructions and handling interrupts are left to the surrounding datapath.

An operation is offered by raising `op_valid` for one cycle while `busy` is low. A direct operation reports its result on the next cycle. An indirect operation holds `busy` high until the pointer has been read.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset `page_o` is 0, and `res_valid`, `idx_we`, `mem_req` and `busy` are all low.
- R2: A direct absolute data operation (field bit 15 = 0, mode bits 14:13 = 00) yields `{page_o, field[12:0]}` with `res_valid` high in the cycle after acceptance, and it makes no memory read.
- R3: For absolute data operations, field bits 14:13 select the indexing mode. 01 adds index+1 and writes index+1 back. 10 adds index−1 and writes index−1 back. 11 adds the index unchanged and writes nothing back. In direct mode the sum wraps within the current 8 KB page.
- R4: An absolute branch (`op_branch`=1, `op_rel`=0) yields all 15 field bits, ignores bits 14:13 as an indexing mode, and loads final-address bits 14:13 into `page_o`. Data operations and relative branches leave `page_o` unchanged, and `page_o` changes only together with `res_valid`.
- R5: In relative mode, field bit 7 is the indirection flag and bits 6:0 are a signed displacement. The displacement is added to `op_npc`, and the result wraps within the 8 KB page of `op_npc`.
- R6: An indirect operation (field bit 15 for absolute, bit 7 for relative) reads the byte at P and then the byte at P+1, where P is the address the direct form would give without indexing. The pointer is `{hi[6:0], lo}`, so bit 7 of the high byte is ignored.
- R7: An indirect indexed data operation adds the updated index to the fetched pointer (post-indexing). The sum wraps over the full 15-bit space, not within a page.
- R8: While `mem_req` is high and `mem_rdy` is low, `mem_req` stays high and `mem_addr` is held. `busy` is high for the whole pointer fetch, `res_valid` is never high while `busy` is, and `op_valid` has no effect while `busy` is high.
- R9: An indirect absolute branch loads `page_o` from bits 14:13 of the fetched target.
- R10: `idx_we` is high only in a `res_valid` cycle, and `idx_wdata` then holds the updated index value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Offers an operation (accepted when `busy` is low) |
| op_branch | input | 1 | 1 = branch operation, 0 = data operation |
| op_rel | input | 1 | 1 = relative displacement field, 0 = absolute field |
| op_field | input | 16 | Address field (relative mode uses bits 7:0) |
| op_npc | input | 15 | Address of the next instruction |
| idx_in | input | 8 | Current value of the named index register |
| busy | output | 1 | Pointer fetch in progress |
| mem_req | output | 1 | Pointer byte read request |
| mem_addr | output | 15 | Pointer byte address |
| mem_rdy | input | 1 | Read completes on this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_rdy` |
| res_valid | output | 1 | One-cycle result strobe |
| res_addr | output | 15 | Final effective address |
| idx_we | output | 1 | Index register write-back strobe |
| idx_wdata | output | 8 | Updated index value |
| page_o | output | 2 | Current page register |

## Verification
Direct absolute fields are tried in each of the four mode encodings. The increment and decrement cases are chosen so that the sum crosses an 8 KB boundary, which separates page-wrapped addition from full-width addition. Relative displacements of both signs at page edges show the wrap and the sign extension. Indirect fetches use pointer bytes with bit 7 set and indexes that carry out of a page, which separate pre-indexing from post-indexing and show the pointer masking. Ready delays of zero and several cycles, plus an operation offered mid-fetch, exercise the handshake and the busy lockout.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
   typedef enum logic [1:0] {
      IX_NONE = 2'b00,
      IX_INC  = 2'b01,
      IX_DEC  = 2'b10,
      IX_ONLY = 2'b11
   } ix_mode_e;

   typedef enum logic {
      ST_IDLE,
      ST_FETCH
   } ea_state_e;
endpackage

// File: rtl/ea_wrap_add.sv
// Adds an offset to a base address; the carry stops at bit WRAP_W so the
// bits above it are kept from the base.
module ea_wrap_add #(
   parameter int AW     = 15,
   parameter int WRAP_W = 13
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] off,
   output logic [AW-1:0] sum
);
   generate
      if (WRAP_W >= AW) begin : g_full
         assign sum = base + off;
      end else begin : g_paged
         logic [WRAP_W-1:0] low_sum;
         assign low_sum = base[WRAP_W-1:0] + off[WRAP_W-1:0];
         assign sum     = {base[AW-1:WRAP_W], low_sum};
      end
   endgenerate
endmodule

// File: rtl/ea_index_step.sv
module ea_index_step
   import ea_gen_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  ix_mode_e           mode,
   input  logic [IDX_W-1:0]   idx_in,
   output logic [IDX_W-1:0]   idx_eff,
   output logic               idx_wr,
   output logic               use_idx
);
   always_comb begin
      idx_eff = idx_in;
      idx_wr  = 1'b0;
      use_idx = 1'b0;
      case (mode)
         IX_INC: begin
            idx_eff = idx_in + IDX_W'(1);
            idx_wr  = 1'b1;
            use_idx = 1'b1;
         end
         IX_DEC: begin
            idx_eff = idx_in - IDX_W'(1);
            idx_wr  = 1'b1;
            use_idx = 1'b1;
         end
         IX_ONLY: use_idx = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/ea_page_reg.sv
module ea_page_reg #(
   parameter int PAGE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] din,
   output logic [PAGE_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
   import ea_gen_pkg::*;
#(
   parameter int AW     = 15,
   parameter int PAGE_W = 2,
   parameter int IDX_W  = 8,
   parameter int DISP_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_branch,
   input  logic              op_rel,
   input  logic [AW:0]       op_field,
   input  logic [AW-1:0]     op_npc,
   input  logic [IDX_W-1:0]  idx_in,
   output logic              busy,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_rdy,
   input  logic [7:0]        mem_rdata,
   output logic              res_valid,
   output logic [AW-1:0]     res_addr,
   output logic              idx_we,
   output logic [IDX_W-1:0]  idx_wdata,
   output logic [PAGE_W-1:0] page_o
);
   localparam int OFF_W     = AW - PAGE_W;
   localparam int PTR_BYTES = (AW + 7) / 8;
   localparam int PTR_W     = PTR_BYTES * 8;
   localparam int CNT_W     = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1;

   generate
      if (AW <= 8 || AW > 24) begin : g_bad_aw
         $error("paged_ea_gen: AW must be 9..24");
      end
      if (PAGE_W < 2 || PAGE_W >= AW) begin : g_bad_page
         $error("paged_ea_gen: PAGE_W must cover the two mode bits and leave offset bits");
      end
      if (DISP_W >= OFF_W || DISP_W < 1) begin : g_bad_disp
         $error("paged_ea_gen: DISP_W must be narrower than the page offset");
      end
      if (IDX_W >= AW) begin : g_bad_idx
         $error("paged_ea_gen: IDX_W must be narrower than AW");
      end
   endgenerate

   ea_state_e          state_q;
   logic [AW-1:0]      base_q;
   logic [CNT_W-1:0]   byte_cnt_q;
   logic [PTR_W-1:0]   ptr_q;
   logic [IDX_W-1:0]   idx_eff_q;
   logic               idx_wr_q;
   logic               use_idx_q;
   logic               br_abs_q;

   // ---- decode of the offered operation ----
   ix_mode_e           op_mode;
   logic               op_ind;
   logic               op_br_abs;
   logic [AW-1:0]      disp_ext;
   logic [AW-1:0]      page_base;
   logic [AW-1:0]      rel_sum;
   logic [AW-1:0]      dir_idx_sum;
   logic [IDX_W-1:0]   idx_eff;
   logic               idx_wr;
   logic               use_idx;
   logic [AW-1:0]      idx_ext;
   logic [AW-1:0]      direct_ea;
   logic [AW-1:0]      fetch_base;

   assign op_ind    = op_rel ? op_field[DISP_W] : op_field[AW];
   assign op_br_abs = op_branch && !op_rel;
   assign op_mode   = (op_rel || op_branch) ? IX_NONE : ix_mode_e'(op_field[AW-1 -: 2]);
   assign disp_ext  = {{(AW-DISP_W){op_field[DISP_W-1]}}, op_field[DISP_W-1:0]};
   assign page_base = {page_o, op_field[OFF_W-1:0]};
   assign idx_ext   = {{(AW-IDX_W){1'b0}}, idx_eff};

   ea_index_step #(.IDX_W(IDX_W)) u_step (
      .mode    (op_mode),
      .idx_in  (idx_in),
      .idx_eff (idx_eff),
      .idx_wr  (idx_wr),
      .use_idx (use_idx)
   );

   ea_wrap_add #(.AW(AW), .WRAP_W(OFF_W)) u_rel_add (
      .base (op_npc),
      .off  (disp_ext),
      .sum  (rel_sum)
   );

   ea_wrap_add #(.AW(AW), .WRAP_W(OFF_W)) u_dir_idx_add (
      .base (page_base),
      .off  (idx_ext),
      .sum  (dir_idx_sum)
   );

   always_comb begin
      if (op_rel)         fetch_base = rel_sum;
      else if (op_branch) fetch_base = op_field[AW-1:0];
      else                fetch_base = page_base;
      direct_ea = (use_idx && !op_rel && !op_branch) ? dir_idx_sum : fetch_base;
   end

   // ---- pointer fetch ----
   logic [AW-1:0]    cnt_ext;
   logic [PTR_W-1:0] ptr_next;
   logic [AW-1:0]    ptr_val;
   logic [AW-1:0]    ind_idx_sum;
   logic [AW-1:0]    ind_ea;
   logic             last_byte;

   assign cnt_ext   = {{(AW-CNT_W){1'b0}}, byte_cnt_q};
   assign ptr_next  = {ptr_q[PTR_W-9:0], mem_rdata};
   assign ptr_val   = ptr_next[AW-1:0];
   assign last_byte = (byte_cnt_q == CNT_W'(PTR_BYTES-1));

   ea_wrap_add #(.AW(AW), .WRAP_W(AW)) u_byte_add (
      .base (base_q),
      .off  (cnt_ext),
      .sum  (mem_addr)
   );

   ea_wrap_add #(.AW(AW), .WRAP_W(AW)) u_ind_idx_add (
      .base (ptr_val),
      .off  ({{(AW-IDX_W){1'b0}}, idx_eff_q}),
      .sum  (ind_idx_sum)
   );

   assign ind_ea  = use_idx_q ? ind_idx_sum : ptr_val;
   assign mem_req = (state_q == ST_FETCH);
   assign busy    = (state_q == ST_FETCH);

   // ---- completion ----
   logic             accept;
   logic             fin_direct;
   logic             fin_ind;
   logic             finish;
   logic [AW-1:0]    fin_addr;
   logic             fin_br_abs;
   logic             fin_idx_wr;
   logic [IDX_W-1:0] fin_idx_val;

   assign accept      = (state_q == ST_IDLE) && op_valid;
   assign fin_direct  = accept && !op_ind;
   assign fin_ind     = (state_q == ST_FETCH) && mem_rdy && last_byte;
   assign finish      = fin_direct || fin_ind;
   assign fin_addr    = fin_direct ? direct_ea : ind_ea;
   assign fin_br_abs  = fin_direct ? op_br_abs : br_abs_q;
   assign fin_idx_wr  = fin_direct ? idx_wr    : idx_wr_q;
   assign fin_idx_val = fin_direct ? idx_eff   : idx_eff_q;

   ea_page_reg #(.PAGE_W(PAGE_W)) u_page (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (finish && fin_br_abs),
      .din   (fin_addr[AW-1 -: PAGE_W]),
      .q     (page_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         base_q     <= '0;
         byte_cnt_q <= '0;
         ptr_q      <= '0;
         idx_eff_q  <= '0;
         idx_wr_q   <= 1'b0;
         use_idx_q  <= 1'b0;
         br_abs_q   <= 1'b0;
         res_valid  <= 1'b0;
         res_addr   <= '0;
         idx_we     <= 1'b0;
         idx_wdata  <= '0;
      end else begin
         res_valid <= finish;
         idx_we    <= finish && fin_idx_wr;
         if (finish) begin
            res_addr  <= fin_addr;
            idx_wdata <= fin_idx_val;
         end
         case (state_q)
            ST_IDLE: begin
               if (accept && op_ind) begin
                  state_q    <= ST_FETCH;
                  base_q     <= fetch_base;
                  byte_cnt_q <= '0;
                  ptr_q      <= '0;
                  idx_eff_q  <= idx_eff;
                  idx_wr_q   <= idx_wr;
                  use_idx_q  <= use_idx && !op_rel && !op_branch;
                  br_abs_q   <= op_br_abs;
               end
            end
            ST_FETCH: begin
               if (mem_rdy) begin
                  ptr_q      <= ptr_next;
                  byte_cnt_q <= byte_cnt_q + CNT_W'(1);
                  if (last_byte) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int AW     = 15,
   parameter int PAGE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_req,
   input logic [AW-1:0]     mem_addr,
   input logic              mem_rdy,
   input logic              res_valid,
   input logic              idx_we,
   input logic [PAGE_W-1:0] page_o
);
   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)))
      else $error("mem_req dropped or mem_addr moved before mem_rdy");

   // R8
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy)
      else $error("mem_req outside busy");

   // R8
   res_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !busy)
      else $error("res_valid while busy");

   // R10
   idx_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |-> res_valid)
      else $error("idx_we without res_valid");

   // R4
   page_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(page_o) |-> res_valid)
      else $error("page_o changed without a result");
endmodule

bind paged_ea_gen ea_gen_chk #(.AW(AW), .PAGE_W(PAGE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_rdy   (mem_rdy),
   .res_valid (res_valid),
   .idx_we    (idx_we),
   .page_o    (page_o)
);

// File: tb/paged_ea_gen_bench.sv
`timescale 1ns/1ps
module paged_ea_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_branch = 1'b0;
   logic        op_rel = 1'b0;
   logic [15:0] op_field = '0;
   logic [14:0] op_npc = '0;
   logic [7:0]  idx_in = '0;
   logic        busy;
   logic        mem_req;
   logic [14:0] mem_addr;
   logic        mem_rdy = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        res_valid;
   logic [14:0] res_addr;
   logic        idx_we;
   logic [7:0]  idx_wdata;
   logic [1:0]  page_o;

   always #10 clk = ~clk;

   paged_ea_gen u_paged_ea_gen (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_branch(op_branch),
      .op_rel(op_rel), .op_field(op_field), .op_npc(op_npc), .idx_in(idx_in),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy),
      .mem_rdata(mem_rdata), .res_valid(res_valid), .res_addr(res_addr),
      .idx_we(idx_we), .idx_wdata(idx_wdata), .page_o(page_o)
   );

   // ---- memory model ----
   logic [7:0]  mem [0:32767];
   int          rdy_delay = 0;
   int          wcnt = 0;
   int          rd_total = 0;
   int          addr_moves = 0;
   logic [14:0] rd_log [0:63];
   logic [14:0] prev_addr = '0;

   always @(negedge clk) begin
      if (mem_req) begin
         if (wcnt > 0 && mem_addr != prev_addr) addr_moves = addr_moves + 1;
         prev_addr = mem_addr;
         if (wcnt >= rdy_delay) begin
            mem_rdy   = 1'b1;
            mem_rdata = mem[mem_addr];
            rd_log[rd_total % 64] = mem_addr;
            rd_total  = rd_total + 1;
            wcnt      = 0;
         end else begin
            mem_rdy = 1'b0;
            wcnt    = wcnt + 1;
         end
      end else begin
         mem_rdy = 1'b0;
         wcnt    = 0;
      end
   end

   // ---- bookkeeping ----
   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic issue(input bit br, input bit rel, input logic [15:0] f,
                        input logic [14:0] npc, input logic [7:0] ix);
      @(negedge clk);
      op_branch = br; op_rel = rel; op_field = f; op_npc = npc; idx_in = ix;
      op_valid  = 1'b1;
      @(negedge clk);
      op_valid  = 1'b0;
   endtask

   task automatic await_res(output int lat);
      lat = 0;
      while (!res_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      if (lat >= 100) check("R8 result timeout", 0, 1);
   endtask

   // ---- scenarios ----
   task automatic t_reset();
      check("R1 page_o", page_o, 0);
      check("R1 res_valid", res_valid, 0);
      check("R1 idx_we", idx_we, 0);
      check("R1 mem_req", mem_req, 0);
      check("R1 busy", busy, 0);
   endtask

   task automatic t_direct();
      int lat;
      int r0 = rd_total;
      issue(0, 0, 16'h0123, 15'h0, 8'h44);
      await_res(lat);
      check("R2 latency", lat, 0);
      check("R2 address", res_addr, 15'h0123);
      check("R2 no reads", rd_total - r0, 0);
      check("R2 no index write", idx_we, 0);
   endtask

   task automatic t_branch();
      int lat;
      issue(1, 0, 16'h4ABC, 15'h0, 8'h11);
      await_res(lat);
      check("R4 branch address", res_addr, 15'h4ABC);
      check("R4 page loaded", page_o, 2);
      check("R4 no index write", idx_we, 0);
      issue(0, 0, 16'h1FFF, 15'h0, 8'h00);
      await_res(lat);
      check("R2 paged address", res_addr, 15'h5FFF);
      check("R4 data keeps page", page_o, 2);
   endtask

   task automatic t_index();
      int lat;
      issue(0, 0, 16'h3FF0, 15'h0, 8'h20);
      await_res(lat);
      check("R3 inc address", res_addr, 15'h4011);
      check("R3 inc we", idx_we, 1);
      check("R10 inc wdata", idx_wdata, 8'h21);
      issue(0, 0, 16'h4010, 15'h0, 8'h00);
      await_res(lat);
      check("R3 dec address", res_addr, 15'h410F);
      check("R3 dec we", idx_we, 1);
      check("R10 dec wdata", idx_wdata, 8'hFF);
      issue(0, 0, 16'h6100, 15'h0, 8'h05);
      await_res(lat);
      check("R3 only address", res_addr, 15'h4105);
      check("R3 only no we", idx_we, 0);
      check("R4 page after data", page_o, 2);
   endtask

   task automatic t_relative();
      int lat;
      issue(0, 1, 16'h0005, 15'h3FFD, 8'h00);
      await_res(lat);
      check("R5 forward wrap", res_addr, 15'h2002);
      issue(1, 1, 16'h007C, 15'h2001, 8'h00);
      await_res(lat);
      check("R5 backward wrap", res_addr, 15'h3FFD);
      check("R5 rel branch keeps page", page_o, 2);
   endtask

   task automatic t_ind_data();
      int lat;
      int r0 = rd_total;
      rdy_delay = 3;
      mem[15'h4200] = 8'hB2;
      mem[15'h4201] = 8'h34;
      issue(0, 0, 16'h8200, 15'h0, 8'h99);
      check("R8 busy during fetch", busy, 1);
      await_res(lat);
      check("R6 pointer", res_addr, 15'h3234);
      check("R6 read count", rd_total - r0, 2);
      check("R6 first read high", rd_log[r0 % 64], 15'h4200);
      check("R6 second read low", rd_log[(r0 + 1) % 64], 15'h4201);
      check("R6 no index write", idx_we, 0);
      check("R4 page after indirect data", page_o, 2);
   endtask

   task automatic t_post_index();
      int lat;
      int r0 = rd_total;
      rdy_delay = 0;
      mem[15'h4300] = 8'h7F;
      mem[15'h4301] = 8'hF0;
      issue(0, 0, 16'hA300, 15'h0, 8'h1F);
      await_res(lat);
      check("R7 post-indexed wrap", res_addr, 15'h0010);
      check("R7 read address", rd_log[r0 % 64], 15'h4300);
      check("R10 we", idx_we, 1);
      check("R10 wdata", idx_wdata, 8'h20);
   endtask

   task automatic t_ind_branch();
      int lat;
      int r0 = rd_total;
      rdy_delay = 1;
      mem[15'h2500] = 8'h61;
      mem[15'h2501] = 8'h23;
      issue(1, 0, 16'hA500, 15'h0, 8'h10);
      await_res(lat);
      check("R9 target", res_addr, 15'h6123);
      check("R9 page from target", page_o, 3);
      check("R4 full-width pointer address", rd_log[r0 % 64], 15'h2500);
      check("R4 branch not indexed", idx_we, 0);
   endtask

   task automatic t_rel_ind();
      int lat;
      int r0 = rd_total;
      rdy_delay = 2;
      mem[15'h601A] = 8'h80;
      mem[15'h601B] = 8'h40;
      issue(1, 1, 16'h008A, 15'h6010, 8'h00);
      await_res(lat);
      check("R5 rel pointer address", rd_log[r0 % 64], 15'h601A);
      check("R6 high bit ignored", res_addr, 15'h0040);
      check("R5 rel indirect keeps page", page_o, 3);
   endtask

   task automatic t_busy_ignore();
      int lat;
      int extra = 0;
      rdy_delay = 4;
      mem[15'h6050] = 8'h12;
      mem[15'h6051] = 8'h34;
      issue(0, 0, 16'h8050, 15'h0, 8'h00);
      check("R8 busy before stray op", busy, 1);
      op_branch = 1'b1; op_rel = 1'b0; op_field = 16'h0777; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      await_res(lat);
      check("R8 result of fetch", res_addr, 15'h1234);
      check("R8 stray op left page", page_o, 3);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (res_valid) extra++;
      end
      check("R8 stray op produced no result", extra, 0);
      check("R8 page still", page_o, 3);
      check("R8 address held while waiting", addr_moves, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      for (int a = 0; a < 32768; a++) mem[a] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_branch();
      t_index();
      t_relative();
      t_ind_data();
      t_post_index();
      t_ind_branch();
      t_rel_ind();
      t_busy_ignore();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      finish_run();
   end
endmodule